// File: doc/BRIEF.md
# Multi-Domain Run Enable and Soft Reset Controller

This block is a small AXI4-Lite slave that owns two control words for a processing core whose logic is split over several clock domains. One word is a self-clearing soft-reset trigger: a write of 1 in bit 0 fires a one-shot reset request for the whole core. The other word is a run enable, which comes out of reset set, so the core runs until software turns it off.

Both controls live on the register clock. The run enable is carried into every core clock domain by a private two-flop synchronizer, and that synchronizer's output is the domain's clock-enable pin. The soft-reset request crosses as a toggle. Each domain detects the toggle edge after its own two-flop synchronizer and stretches it into a reset pulse of a fixed number of its own cycles.

A build parameter removes the register interface altogether. In that build every domain's enable is tied high and no soft reset is ever issued.

Top module: `mdrc_top`

## Requirements
- R1: After the register-side reset (active low), a read of offset 0x4 returns 1 and a read of 0x0 returns 0. Every core_ce bit is 1 once its domain has left reset and seen 3 core clock edges.
- R2: A write to offset 0x4 with wstrb[0]=1 sets the run enable to wdata[0]. Later reads of 0x4 return the enable in bit 0 and zeros above it.
- R3: core_ce[i] takes the new enable value no later than the third rising edge of core_clk[i] after the register write completes.
- R4: A write to offset 0x0 with wstrb[0]=1 and wdata[0]=1 drives core_soft_rst[i] high for exactly RST_HOLD (default 2) consecutive core_clk[i] cycles, as one pulse in every domain, provided writes are spaced at least 6 cycles of the slowest core clock apart.
- R5: Offset 0x0 always reads 0. A write of wdata[0]=0 there produces no reset pulse.
- R6: A write with wstrb[0]=0 changes neither control, whatever the data. Data bits above bit 0 are ignored.
- R7: Reads of any other word offset (0x8, 0xC) return 0, and writes there change nothing. Every response is OKAY (bresp and rresp equal 2'b00).
- R8: bvalid rises one register cycle after the later of the write-address and write-data handshakes, never before both, and stays high until bready. rvalid stays high with stable rdata until rready.
- R9: A soft-reset write leaves the run enable unchanged.
- R10: With REG_IF_EN=0, every core_ce bit is 1 after its domain leaves reset, and core_soft_rst stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register interface clock |
| reg_rst_n | input | 1 | Register interface reset, active low, asynchronous |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes (only bit 0 used) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_clk | input | NDOM | One clock per core domain |
| core_rst_n | input | NDOM | Per-domain reset, active low, asynchronous |
| core_ce | output | NDOM | Per-domain synchronized clock enable |
| core_soft_rst | output | NDOM | Per-domain stretched soft-reset pulse |

## Verification
Register-side results are exact to the cycle. bvalid is sampled low on the falling edge after the data handshake and high on the next, and rdata is sampled on the falling edge after the address handshake, with the bench holding the ready low for one more cycle to see the value stay put. Results in the core domains land a fixed number of destination edges after the write: the enable within three edges and the reset pulse between the third and fifth. The bench therefore waits past the slowest domain's bound before comparing core_ce with its model. It counts pulse edges and high cycles per domain, sampled on each domain's own falling edge, and compares the increments against the number of triggering writes in that interval.

// File: rtl/mdrc_pkg.sv
package mdrc_pkg;
    // AXI response codes
    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Word indices (byte offset / 4) of the control words
    localparam int unsigned WORD_SOFT_RST = 0;
    localparam int unsigned WORD_RUN_EN   = 1;
endpackage

// File: rtl/mdrc_axil_regs.sv
module mdrc_axil_regs #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     awaddr,
    input  logic                  awvalid,
    output logic                  awready,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [DATA_W/8-1:0]   wstrb,
    input  logic                  wvalid,
    output logic                  wready,
    output logic [1:0]            bresp,
    output logic                  bvalid,
    input  logic                  bready,
    input  logic [ADDR_W-1:0]     araddr,
    input  logic                  arvalid,
    output logic                  arready,
    output logic [DATA_W-1:0]     rdata,
    output logic [1:0]            rresp,
    output logic                  rvalid,
    input  logic                  rready,
    output logic                  run_en,
    output logic                  rst_toggle
);
    import mdrc_pkg::*;

    localparam int unsigned WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic              aw_got;
        logic [WORD_W-1:0] aw_word;
        logic              w_got;
        logic              w_bit0;
        logic              w_strb0;
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
        logic              en;
        logic              tog;
    } regs_t;

    regs_t st_d, st_q;

    // Only bit 0 of the data and strobe, and the word index of the address, matter.
    logic unused_in_bits;
    assign unused_in_bits = ^{wdata[DATA_W-1:1], wstrb[DATA_W/8-1:1],
                              awaddr[1:0], araddr[1:0]};

    always_comb begin
        st_d = st_q;

        awready = !st_q.aw_got && !st_q.bvalid;
        wready  = !st_q.w_got  && !st_q.bvalid;
        arready = !st_q.rvalid;

        // Capture address and data independently
        if (awvalid && awready) begin
            st_d.aw_got  = 1'b1;
            st_d.aw_word = awaddr[ADDR_W-1:2];
        end
        if (wvalid && wready) begin
            st_d.w_got   = 1'b1;
            st_d.w_bit0  = wdata[0];
            st_d.w_strb0 = wstrb[0];
        end

        // Commit once both halves are held
        if (st_q.aw_got && st_q.w_got) begin
            st_d.aw_got = 1'b0;
            st_d.w_got  = 1'b0;
            st_d.bvalid = 1'b1;
            if (st_q.w_strb0) begin
                if (st_q.aw_word == WORD_W'(WORD_SOFT_RST)) begin
                    if (st_q.w_bit0) begin
                        st_d.tog = ~st_q.tog;
                    end
                end else if (st_q.aw_word == WORD_W'(WORD_RUN_EN)) begin
                    st_d.en = st_q.w_bit0;
                end
            end
        end
        if (st_q.bvalid && bready) begin
            st_d.bvalid = 1'b0;
        end

        // Read path
        if (arvalid && arready) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = '0;
            if (araddr[ADDR_W-1:2] == WORD_W'(WORD_RUN_EN)) begin
                st_d.rdata[0] = st_q.en;
            end
        end else if (st_q.rvalid && rready) begin
            st_d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bvalid     = st_q.bvalid;
    assign bresp      = RESP_OKAY;
    assign rvalid     = st_q.rvalid;
    assign rdata      = st_q.rdata;
    assign rresp      = RESP_OKAY;
    assign run_en     = st_q.en;
    assign rst_toggle = st_q.tog;
endmodule

// File: rtl/mdrc_level_sync.sv
module mdrc_level_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdrc_pulse_sync.sv
module mdrc_pulse_sync #(
    parameter int unsigned STAGES   = 2,
    parameter int unsigned HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse_out
);
    localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [STAGES:0]  chain;
        logic [CNT_W-1:0] cnt;
    } ps_t;

    ps_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-1:0], tog_in};
        if (st_q.chain[STAGES] != st_q.chain[STAGES-1]) begin
            st_d.cnt = CNT_W'(HOLD_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_out = (st_q.cnt != '0);
endmodule

// File: rtl/mdrc_top.sv
module mdrc_top #(
    parameter int unsigned NDOM        = 3,
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RST_HOLD    = 2,
    parameter bit          REG_IF_EN   = 1'b1
) (
    input  logic                  reg_clk,
    input  logic                  reg_rst_n,
    input  logic [ADDR_W-1:0]     s_awaddr,
    input  logic                  s_awvalid,
    output logic                  s_awready,
    input  logic [DATA_W-1:0]     s_wdata,
    input  logic [DATA_W/8-1:0]   s_wstrb,
    input  logic                  s_wvalid,
    output logic                  s_wready,
    output logic [1:0]            s_bresp,
    output logic                  s_bvalid,
    input  logic                  s_bready,
    input  logic [ADDR_W-1:0]     s_araddr,
    input  logic                  s_arvalid,
    output logic                  s_arready,
    output logic [DATA_W-1:0]     s_rdata,
    output logic [1:0]            s_rresp,
    output logic                  s_rvalid,
    input  logic                  s_rready,
    input  logic [NDOM-1:0]       core_clk,
    input  logic [NDOM-1:0]       core_rst_n,
    output logic [NDOM-1:0]       core_ce,
    output logic [NDOM-1:0]       core_soft_rst
);
    logic run_en;
    logic rst_toggle;

    if (REG_IF_EN) begin : g_regif
        mdrc_axil_regs #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk        (reg_clk),
            .rst_n      (reg_rst_n),
            .awaddr     (s_awaddr),
            .awvalid    (s_awvalid),
            .awready    (s_awready),
            .wdata      (s_wdata),
            .wstrb      (s_wstrb),
            .wvalid     (s_wvalid),
            .wready     (s_wready),
            .bresp      (s_bresp),
            .bvalid     (s_bvalid),
            .bready     (s_bready),
            .araddr     (s_araddr),
            .arvalid    (s_arvalid),
            .arready    (s_arready),
            .rdata      (s_rdata),
            .rresp      (s_rresp),
            .rvalid     (s_rvalid),
            .rready     (s_rready),
            .run_en     (run_en),
            .rst_toggle (rst_toggle)
        );
    end else begin : g_noregif
        // No register interface: core always enabled, never soft-reset.
        assign run_en     = 1'b1;
        assign rst_toggle = 1'b0;
        assign s_awready  = 1'b0;
        assign s_wready   = 1'b0;
        assign s_bresp    = mdrc_pkg::RESP_OKAY;
        assign s_bvalid   = 1'b0;
        assign s_arready  = 1'b0;
        assign s_rdata    = '0;
        assign s_rresp    = mdrc_pkg::RESP_OKAY;
        assign s_rvalid   = 1'b0;
        logic unused_axi_in;
        assign unused_axi_in = ^{reg_clk, reg_rst_n, s_awaddr, s_awvalid, s_wdata,
                                 s_wstrb, s_wvalid, s_bready, s_araddr, s_arvalid,
                                 s_rready};
    end

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        mdrc_level_sync #(
            .STAGES (SYNC_STAGES)
        ) u_ce_sync (
            .clk   (core_clk[g]),
            .rst_n (core_rst_n[g]),
            .din   (run_en),
            .dout  (core_ce[g])
        );

        mdrc_pulse_sync #(
            .STAGES   (SYNC_STAGES),
            .HOLD_CYC (RST_HOLD)
        ) u_rst_sync (
            .clk       (core_clk[g]),
            .rst_n     (core_rst_n[g]),
            .tog_in    (rst_toggle),
            .pulse_out (core_soft_rst[g])
        );
    end
endmodule

// File: rtl/mdrc_chk.sv
module mdrc_chk #(
    parameter int unsigned NDOM   = 3,
    parameter int unsigned DATA_W = 32
) (
    input logic              reg_clk,
    input logic              reg_rst_n,
    input logic              s_awready,
    input logic              s_wready,
    input logic [1:0]        s_bresp,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [DATA_W-1:0] s_rdata,
    input logic [1:0]        s_rresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input logic [NDOM-1:0]   core_clk,
    input logic [NDOM-1:0]   core_rst_n,
    input logic [NDOM-1:0]   core_soft_rst
);
    // R7: every write response is OKAY
    p_bresp_okay_r7: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        s_bvalid |-> s_bresp == 2'b00);

    // R7: every read response is OKAY
    p_rresp_okay_r7: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        s_rvalid |-> s_rresp == 2'b00);

    // R8: response only once both channels have been taken
    p_b_after_both_r8: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        $rose(s_bvalid) |-> ($past(!s_awready) && $past(!s_wready)));

    // R8: write response held until accepted
    p_b_hold_r8: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        (s_bvalid && !s_bready) |=> s_bvalid);

    // R8: read data held stable until accepted
    p_r_hold_r8: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    for (genvar g = 0; g < NDOM; g++) begin : g_dom_chk
        // R4: soft reset lasts at least two destination cycles
        p_rst_two_cyc_r4: assert property (@(posedge core_clk[g]) disable iff (!core_rst_n[g])
            $rose(core_soft_rst[g]) |=> core_soft_rst[g]);
    end
endmodule

bind mdrc_top mdrc_chk #(
    .NDOM   (NDOM),
    .DATA_W (DATA_W)
) u_chk (
    .reg_clk       (reg_clk),
    .reg_rst_n     (reg_rst_n),
    .s_awready     (s_awready),
    .s_wready      (s_wready),
    .s_bresp       (s_bresp),
    .s_bvalid      (s_bvalid),
    .s_bready      (s_bready),
    .s_rdata       (s_rdata),
    .s_rresp       (s_rresp),
    .s_rvalid      (s_rvalid),
    .s_rready      (s_rready),
    .core_clk      (core_clk),
    .core_rst_n    (core_rst_n),
    .core_soft_rst (core_soft_rst)
);

// File: tb/mdrc_top_tb.sv
module mdrc_top_tb;
    localparam int NDOM     = 3;
    localparam int RST_HOLD = 2;

    logic        reg_clk = 1'b0;
    logic        reg_rst_n = 1'b0;
    logic [3:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [3:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;
    logic        ck0 = 1'b0, ck1 = 1'b0, ck2 = 1'b0;
    logic [NDOM-1:0] core_clk;
    logic [NDOM-1:0] core_rst_n = '0;
    logic [NDOM-1:0] core_ce;
    logic [NDOM-1:0] core_soft_rst;

    // second build without register interface
    logic        nr_awready, nr_wready, nr_bvalid, nr_arready, nr_rvalid;
    logic [1:0]  nr_bresp, nr_rresp;
    logic [31:0] nr_rdata;
    logic [NDOM-1:0] nr_ce, nr_soft_rst;

    always #2.5 reg_clk = ~reg_clk;
    always #3.5 ck0 = ~ck0;
    always #5.5 ck1 = ~ck1;
    always #6.5 ck2 = ~ck2;
    assign core_clk = {ck2, ck1, ck0};

    mdrc_top #(.NDOM(NDOM), .RST_HOLD(RST_HOLD)) u_dut (
        .reg_clk(reg_clk), .reg_rst_n(reg_rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .core_ce(core_ce), .core_soft_rst(core_soft_rst)
    );

    mdrc_top #(.NDOM(NDOM), .RST_HOLD(RST_HOLD), .REG_IF_EN(1'b0)) u_dut_noreg (
        .reg_clk(reg_clk), .reg_rst_n(reg_rst_n),
        .s_awaddr(4'h0), .s_awvalid(1'b0), .s_awready(nr_awready),
        .s_wdata(32'h0), .s_wstrb(4'h0), .s_wvalid(1'b0), .s_wready(nr_wready),
        .s_bresp(nr_bresp), .s_bvalid(nr_bvalid), .s_bready(1'b0),
        .s_araddr(4'h0), .s_arvalid(1'b0), .s_arready(nr_arready),
        .s_rdata(nr_rdata), .s_rresp(nr_rresp), .s_rvalid(nr_rvalid), .s_rready(1'b0),
        .core_clk(core_clk), .core_rst_n(core_rst_n),
        .core_ce(nr_ce), .core_soft_rst(nr_soft_rst)
    );

    // Per-domain pulse monitors, sampled on each domain's falling edge
    logic [15:0] hi_w [NDOM];
    logic [15:0] st_w [NDOM];
    for (genvar g = 0; g < NDOM; g++) begin : g_mon
        logic [15:0] hi_cnt = '0;
        logic [15:0] st_cnt = '0;
        logic        prev   = 1'b0;
        always @(negedge core_clk[g]) begin
            if (core_soft_rst[g]) hi_cnt <= hi_cnt + 16'd1;
            if (core_soft_rst[g] && !prev) st_cnt <= st_cnt + 16'd1;
            prev <= core_soft_rst[g];
        end
        assign hi_w[g] = hi_cnt;
        assign st_w[g] = st_cnt;
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic exp_en;
    int   exp_pulses;
    logic [15:0] hi_snap [NDOM];
    logic [15:0] st_snap [NDOM];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NDOM-1:0] ce_model(input logic en);
        return en ? {NDOM{1'b1}} : {NDOM{1'b0}};
    endfunction

    task automatic axi_write(input logic [3:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int wdly);
        @(negedge reg_clk);
        awaddr = a; awvalid = 1'b1; wdata = d; wstrb = s; wvalid = (wdly == 0);
        chk(awready == 1'b1, "R8 awready idle", 32'(awready), 32'h1);
        @(posedge reg_clk);
        @(negedge reg_clk);
        awvalid = 1'b0;
        if (wdly > 0) begin
            for (int i = 0; i < wdly; i++) begin
                chk(bvalid == 1'b0, "R8 no response before data", 32'(bvalid), 32'h0);
                @(negedge reg_clk);
            end
            wvalid = 1'b1;
            @(posedge reg_clk);
            @(negedge reg_clk);
        end
        wvalid = 1'b0;
        chk(bvalid == 1'b0, "R8 bvalid not in handshake cycle", 32'(bvalid), 32'h0);
        @(negedge reg_clk);
        chk(bvalid == 1'b1, "R8 bvalid one cycle later", 32'(bvalid), 32'h1);
        chk(bresp == 2'b00, "R7 bresp OKAY", 32'(bresp), 32'h0);
        @(negedge reg_clk);
        chk(bvalid == 1'b1, "R8 bvalid held", 32'(bvalid), 32'h1);
        bready = 1'b1;
        @(negedge reg_clk);
        bready = 1'b0;
        chk(bvalid == 1'b0, "R8 bvalid cleared", 32'(bvalid), 32'h0);
    endtask

    task automatic axi_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge reg_clk);
        araddr = a; arvalid = 1'b1;
        @(posedge reg_clk);
        @(negedge reg_clk);
        arvalid = 1'b0;
        chk(rvalid == 1'b1, "R8 rvalid after address", 32'(rvalid), 32'h1);
        chk(rresp == 2'b00, "R7 rresp OKAY", 32'(rresp), 32'h0);
        d = rdata;
        @(negedge reg_clk);
        chk(rvalid == 1'b1 && rdata == d, "R8 read data held", rdata, d);
        rready = 1'b1;
        @(negedge reg_clk);
        rready = 1'b0;
    endtask

    task automatic snap();
        for (int g = 0; g < NDOM; g++) begin
            hi_snap[g] = hi_w[g];
            st_snap[g] = st_w[g];
        end
        exp_pulses = 0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        #200;
        chk(core_ce == ce_model(exp_en), {tag, " R3 core_ce"}, 32'(core_ce),
            32'(ce_model(exp_en)));
        for (int g = 0; g < NDOM; g++) begin
            chk(st_w[g] - st_snap[g] == 16'(exp_pulses), {tag, " R4 pulse count"},
                32'(st_w[g] - st_snap[g]), 32'(exp_pulses));
            chk(hi_w[g] - hi_snap[g] == 16'(exp_pulses * RST_HOLD), {tag, " R4 pulse length"},
                32'(hi_w[g] - hi_snap[g]), 32'(exp_pulses * RST_HOLD));
        end
        axi_read(4'h4, d);
        chk(d == {31'b0, exp_en}, {tag, " R2 enable readback"}, d, {31'b0, exp_en});
        axi_read(4'h0, d);
        chk(d == 32'h0, {tag, " R5 reset word reads 0"}, d, 32'h0);
        axi_read(4'h8, d);
        chk(d == 32'h0, {tag, " R7 unmapped reads 0"}, d, 32'h0);
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d,
                            input logic [3:0] s, input int wdly, input string tag);
        snap();
        axi_write(a, d, s, wdly);
        if (s[0]) begin
            if (a[3:2] == 2'd0 && d[0]) exp_pulses = 1;
            if (a[3:2] == 2'd1) exp_en = d[0];
        end
        check_all(tag);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        exp_en = 1'b1;
        repeat (4) @(negedge reg_clk);
        reg_rst_n = 1'b1;
        core_rst_n = '1;
        #100;
        // R1: reset state
        chk(core_ce == {NDOM{1'b1}}, "R1 core_ce after reset", 32'(core_ce), 32'h7);
        chk(core_soft_rst == '0, "R1 no soft reset after reset", 32'(core_soft_rst), 32'h0);
        chk(nr_ce == {NDOM{1'b1}}, "R10 no-register build enabled", 32'(nr_ce), 32'h7);
        axi_read(4'h4, d);
        chk(d == 32'h1, "R1 enable resets to 1", d, 32'h1);
        axi_read(4'h0, d);
        chk(d == 32'h0, "R1 reset word reads 0", d, 32'h0);

        // Directed cases
        do_write(4'h4, 32'h0, 4'h1, 0, "R2 disable");
        // R3: timing bound of three slowest edges
        axi_write(4'h4, 32'h1, 4'h1, 0);
        #40;
        chk(core_ce == 3'b111, "R3 ce within three edges", 32'(core_ce), 32'h7);
        exp_en = 1'b1;
        do_write(4'h0, 32'h1, 4'h1, 2, "R4 soft reset");
        do_write(4'h4, 32'h0, 4'h1, 1, "R2 disable again");
        do_write(4'h0, 32'hFFFF_FFFF, 4'hF, 0, "R9 soft reset keeps enable");
        do_write(4'h0, 32'hFFFF_FFFE, 4'hF, 0, "R5 write 0 no pulse");
        do_write(4'h4, 32'h1, 4'hE, 3, "R6 strobe 0 ignored");
        do_write(4'h4, 32'hFFFF_FFFE, 4'h1, 0, "R6 upper bits ignored");
        do_write(4'h8, 32'h1, 4'hF, 0, "R7 unmapped write");
        do_write(4'hC, 32'h1, 4'hF, 1, "R7 unmapped write C");
        do_write(4'h5, 32'h1, 4'h1, 0, "R2 low address bits ignored");

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [3:0] a;
            a = {2'($urandom_range(0, 3)), 2'b00};
            do_write(a, $urandom, 4'($urandom), int'($urandom_range(0, 3)), "random");
        end

        chk(nr_ce == {NDOM{1'b1}}, "R10 no-register build stays enabled", 32'(nr_ce), 32'h7);
        chk(nr_soft_rst == '0, "R10 no-register build no soft reset", 32'(nr_soft_rst), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Ongoing R10 check: no-register build never pulses
    always @(negedge ck2) begin
        if (core_rst_n[2] && !done && nr_soft_rst != '0) begin
            chk(1'b0, "R10 unexpected soft reset", 32'(nr_soft_rst), 32'h0);
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule